// File: doc/BRIEF.md
# Serial Port Flow-Control Gate

This block decides when a byte that is waiting in the transmit holding register may be handed to the transmit shifter, and it conditions the receive-side handshake pins of one asynchronous serial port. A configuration bit turns flow control on, and a second bit picks how the port's handshake pins are used. With the mode bit clear, the port uses a clear-to-send input that gates transmission. With the mode bit set, the port instead uses an enable-receiver request input and a ready output that reports free space in the receive buffer.

Clear-to-send is looked at only when a frame is about to begin. Once the gate has issued a one-cycle start pulse to the shifter, it holds that frame as active until the shifter answers with a done pulse, whatever the clear-to-send pin does meanwhile. Both asynchronous handshake inputs pass through a flop chain of configurable depth (two by default) before any logic uses them.

Top module: `sio_flow_gate`

## Requirements
- R1: While rst_n is low, frame_start, tx_active, rx_enable and rx_ready are all 0 after the next clock edge.
- R2: frame_start is a single-cycle pulse: it is never high on two consecutive cycles.
- R3: Once frame_start has pulsed, tx_active is 1 and no further frame_start occurs until the cycle after frame_done is seen high.
- R4: With fc_en=1 and rx_mode=0, an idle gate issues no frame_start while the synchronised clear-to-send is 0, even with thr_valid=1.
- R5: With fc_en=0, an idle gate pulses frame_start on the edge after it sees thr_valid=1, whatever cts_in is.
- R6: With rx_mode=1, cts_in has no effect on transmission: an idle gate with thr_valid=1 starts on the next edge.
- R7: Dropping cts_in while a frame is active neither ends the frame nor clears tx_active; only frame_done does.
- R8: With fc_en=1 and rx_mode=1, rx_enable equals rx_req_in delayed by SYNC_STAGES+1 clock edges.
- R9: When fc_en=0 or rx_mode=0, rx_enable is 1 on the edge after that condition is seen.
- R10: rx_ready is 1 one edge after fc_en=1, rx_mode=1 and rx_full=0 are seen together, and 0 one edge after any other combination.
- R11: A change on cts_in reaches the start decision only after SYNC_STAGES clock edges; a pulse that is gone before then still reaches it, delayed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| fc_en | input | 1 | Flow-control enable |
| rx_mode | input | 1 | 0: clear-to-send use, 1: receive request/ready use |
| cts_in | input | 1 | Clear-to-send, active high, asynchronous |
| rx_req_in | input | 1 | Enable-receiver request, active high, asynchronous |
| thr_valid | input | 1 | Transmit holding register holds a byte |
| frame_done | input | 1 | Shifter has finished the current frame (one-cycle pulse) |
| rx_full | input | 1 | Receive buffer has no free space |
| frame_start | output | 1 | One-cycle pulse telling the shifter to load and send |
| tx_active | output | 1 | A frame has started and is not yet done |
| rx_enable | output | 1 | Receiver enable |
| rx_ready | output | 1 | Ready-to-receive indication |

## Verification
The assertions take for granted that frame_done is a single-cycle pulse that arrives only while a frame is active, and that fc_en and rx_mode are not changed in the middle of a frame. The bench keeps to this with a small shifter stand-in that returns frame_done a set number of cycles after each observed start pulse. It changes the configuration bits only at the boundaries between test phases. All inputs, including the nominally asynchronous ones, are driven on the falling edge so that the synchroniser latency is well defined.

// File: rtl/sio_flow_pkg.sv
package sio_flow_pkg;

    typedef enum logic [0:0] {
        TX_IDLE = 1'b0,
        TX_BUSY = 1'b1
    } tx_state_e;

    typedef struct packed {
        tx_state_e state;
        logic      start;
    } tx_regs_t;

    typedef struct packed {
        logic enable;
        logic ready;
    } rx_regs_t;

    localparam int unsigned SYNC_W = 2;
    localparam int unsigned SYNC_CTS_BIT = 0;
    localparam int unsigned SYNC_REQ_BIT = 1;

endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < int'(STAGES); i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[LAST];

    generate
        if (STAGES > 1) begin : g_chain_check
            p_sync_shift_r11: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (chain_q[1] == $past(chain_q[0])));
        end
    endgenerate

endmodule

// File: rtl/sio_tx_gate.sv
module sio_tx_gate
    import sio_flow_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fc_en,
    input  logic rx_mode,
    input  logic cts_ok,
    input  logic thr_valid,
    input  logic frame_done,
    output logic frame_start,
    output logic tx_active
);
    tx_regs_t tx_d, tx_q;
    logic     permit;

    // Clear-to-send only matters with flow control on and pins in CTS use.
    assign permit = !fc_en || rx_mode || cts_ok;

    always_comb begin
        tx_d       = tx_q;
        tx_d.start = 1'b0;
        unique case (tx_q.state)
            TX_IDLE: begin
                if (thr_valid && permit) begin
                    tx_d.start = 1'b1;
                    tx_d.state = TX_BUSY;
                end
            end
            TX_BUSY: begin
                if (frame_done) tx_d.state = TX_IDLE;
            end
            default: tx_d.state = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tx_q <= '{state: TX_IDLE, start: 1'b0};
        else        tx_q <= tx_d;
    end

    assign frame_start = tx_q.start;
    assign tx_active   = (tx_q.state == TX_BUSY);

    p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    p_hold_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && !frame_done) |=> (tx_active && !frame_start));

    p_cts_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_active && fc_en && !rx_mode && !cts_ok) |=> !frame_start);

    p_free_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_active && !fc_en && thr_valid) |=> frame_start);

    p_cts_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_active && rx_mode && thr_valid) |=> frame_start);

    p_no_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && !cts_ok && !frame_done) |=> tx_active);

endmodule

// File: rtl/sio_rx_gate.sv
module sio_rx_gate
    import sio_flow_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fc_en,
    input  logic rx_mode,
    input  logic req_sync,
    input  logic rx_full,
    output logic rx_enable,
    output logic rx_ready
);
    rx_regs_t rx_d, rx_q;
    logic     req_mode;

    assign req_mode = fc_en && rx_mode;

    always_comb begin
        rx_d = rx_q;
        if (req_mode) begin
            rx_d.enable = req_sync;
            rx_d.ready  = !rx_full;
        end else begin
            rx_d.enable = 1'b1;
            rx_d.ready  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rx_q <= '{enable: 1'b0, ready: 1'b0};
        else        rx_q <= rx_d;
    end

    assign rx_enable = rx_q.enable;
    assign rx_ready  = rx_q.ready;

    p_req_gates_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_en && rx_mode && !req_sync) |=> !rx_enable);

    p_enable_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!fc_en || !rx_mode) |=> rx_enable);

    p_full_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |=> !rx_ready);

    p_ready_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!fc_en || !rx_mode) |=> !rx_ready);

endmodule

// File: rtl/sio_flow_gate.sv
module sio_flow_gate
    import sio_flow_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fc_en,
    input  logic rx_mode,
    input  logic cts_in,
    input  logic rx_req_in,
    input  logic thr_valid,
    input  logic frame_done,
    input  logic rx_full,
    output logic frame_start,
    output logic tx_active,
    output logic rx_enable,
    output logic rx_ready
);
    logic [SYNC_W-1:0] async_in, synced;

    always_comb begin
        async_in               = '0;
        async_in[SYNC_CTS_BIT] = cts_in;
        async_in[SYNC_REQ_BIT] = rx_req_in;
    end

    sio_sync #(
        .WIDTH  (SYNC_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (async_in),
        .dout  (synced)
    );

    sio_tx_gate u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .fc_en       (fc_en),
        .rx_mode     (rx_mode),
        .cts_ok      (synced[SYNC_CTS_BIT]),
        .thr_valid   (thr_valid),
        .frame_done  (frame_done),
        .frame_start (frame_start),
        .tx_active   (tx_active)
    );

    sio_rx_gate u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .fc_en     (fc_en),
        .rx_mode   (rx_mode),
        .req_sync  (synced[SYNC_REQ_BIT]),
        .rx_full   (rx_full),
        .rx_enable (rx_enable),
        .rx_ready  (rx_ready)
    );

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!frame_start && !tx_active && !rx_enable && !rx_ready));

endmodule

// File: tb/sio_flow_gate_bench.sv
module sio_flow_gate_bench;
    localparam int SYNC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fc_en = 1'b0, rx_mode = 1'b0, cts_in = 1'b0, rx_req_in = 1'b0;
    logic thr_valid = 1'b0, frame_done = 1'b0, rx_full = 1'b0;
    logic frame_start, tx_active, rx_enable, rx_ready;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    string cur_req = "R1";
    bit compare_on = 1'b0;
    int done_delay = 3;
    int done_cnt = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    sio_flow_gate #(.SYNC_STAGES(SYNC)) u_sio_flow_gate (
        .clk(clk), .rst_n(rst_n), .fc_en(fc_en), .rx_mode(rx_mode),
        .cts_in(cts_in), .rx_req_in(rx_req_in), .thr_valid(thr_valid),
        .frame_done(frame_done), .rx_full(rx_full),
        .frame_start(frame_start), .tx_active(tx_active),
        .rx_enable(rx_enable), .rx_ready(rx_ready)
    );

    // Behavioural reference model
    bit cts_hist[$];
    bit req_hist[$];
    bit m_start, m_busy, m_en, m_rdy;

    always @(posedge clk) begin
        if (!rst_n) begin
            cts_hist.delete();
            req_hist.delete();
            for (int i = 0; i < SYNC; i++) begin
                cts_hist.push_back(1'b0);
                req_hist.push_back(1'b0);
            end
            m_start = 1'b0; m_busy = 1'b0; m_en = 1'b0; m_rdy = 1'b0;
        end else begin
            bit sc, sr, ok;
            sc = cts_hist.pop_front();
            cts_hist.push_back(cts_in);
            sr = req_hist.pop_front();
            req_hist.push_back(rx_req_in);
            ok = !fc_en || rx_mode || sc;
            if (!m_busy) begin
                m_start = thr_valid && ok;
                if (m_start) m_busy = 1'b1;
            end else begin
                m_start = 1'b0;
                if (frame_done) m_busy = 1'b0;
            end
            m_en  = (fc_en && rx_mode) ? sr : 1'b1;
            m_rdy = fc_en && rx_mode && !rx_full;
        end
    end

    task automatic check(input string req, input string name, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d", req, name, act, exp, cycles);
        end
    endtask

    // Compare on every clock, away from the rising edge
    always @(negedge clk) begin
        cycles++;
        if (compare_on && rst_n) begin
            check(cur_req, "frame_start", frame_start, m_start);
            check(cur_req, "tx_active", tx_active, m_busy);
            check(cur_req, "rx_enable", rx_enable, m_en);
            check(cur_req, "rx_ready", rx_ready, m_rdy);
        end
    end

    // Shifter stand-in: answers each start with a done pulse
    always @(negedge clk) begin
        frame_done = 1'b0;
        if (frame_start) done_cnt = done_delay;
        else if (done_cnt > 0) begin
            done_cnt--;
            if (done_cnt == 0) frame_done = 1'b1;
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int starts;
        run(3);
        check("R1", "frame_start", frame_start, 1'b0);
        check("R1", "tx_active", tx_active, 1'b0);
        check("R1", "rx_enable", rx_enable, 1'b0);
        check("R1", "rx_ready", rx_ready, 1'b0);
        rst_n = 1'b1;
        compare_on = 1'b1;

        // Flow control off: CTS low does not hold data back
        cur_req = "R5"; fc_en = 0; rx_mode = 0; cts_in = 0; thr_valid = 1; done_delay = 4;
        run(20);
        starts = 0;
        for (int i = 0; i < 30; i++) begin
            thr_valid = (i % 7) != 3;
            run(1);
            if (frame_start) starts++;
        end
        total++;
        if (starts == 0) begin
            bad++;
            $display("FAIL R5 starts actual=%0d expected=nonzero", starts);
        end
        thr_valid = 1;

        cur_req = "R2"; done_delay = 1; run(20);
        cur_req = "R3"; done_delay = 12; run(40);

        // CTS use: low clear-to-send blocks
        cur_req = "R4"; fc_en = 1; rx_mode = 0; cts_in = 0; done_delay = 3;
        run(40);
        total++;
        if (frame_start !== 1'b0 || tx_active !== 1'b0) begin
            bad++;
            $display("FAIL R4 tx_active actual=%0b expected=0", tx_active);
        end

        // Synchroniser latency and short pulses
        cur_req = "R11";
        cts_in = 1; run(1); cts_in = 0; run(15);
        cts_in = 1; run(2); cts_in = 0; run(15);
        cts_in = 1; run(10);

        // CTS dropped mid-frame
        cur_req = "R7"; done_delay = 10;
        for (int k = 0; k < 3; k++) begin
            cts_in = 1;
            while (!frame_start) run(1);
            cts_in = 0;
            run(5);
            total++;
            if (tx_active !== 1'b1) begin
                bad++;
                $display("FAIL R7 tx_active actual=%0b expected=1", tx_active);
            end
            run(10);
        end

        // Enable-request mode: CTS ignored
        cur_req = "R6"; rx_mode = 1; cts_in = 0; done_delay = 2; run(30);

        cur_req = "R8"; rx_full = 0;
        for (int i = 0; i < 40; i++) begin
            rx_req_in = ((i / 3) % 2) == 1 || i == 20;
            run(1);
        end
        rx_req_in = 0; run(6);

        cur_req = "R10";
        for (int i = 0; i < 24; i++) begin
            rx_full = (i % 5) < 2;
            run(1);
        end
        fc_en = 0; rx_full = 0; run(6);
        fc_en = 1; rx_mode = 0; run(6);
        rx_mode = 1; run(4);

        cur_req = "R9"; rx_req_in = 0;
        fc_en = 0; run(8);
        fc_en = 1; rx_mode = 0; run(8);
        rx_mode = 1; run(8);

        // Reset in the middle of a frame
        cur_req = "R1"; done_delay = 20; run(3);
        rst_n = 0; run(2);
        check("R1", "tx_active", tx_active, 1'b0);
        check("R1", "rx_ready", rx_ready, 1'b0);
        rst_n = 1; run(10);

        finish_run();
    end

endmodule